// File: doc/BRIEF.md
# Serial Priority Interrupt Chain

This block gathers interrupt requests from a row of device stages and presents them to a processor over a single shared request line. Each stage holds a request flag that its device sets with a one-cycle pulse. The processor's acknowledge enters the first stage and travels down the row. A stage that has no pending flag passes the acknowledge on to the next stage. The first stage that has a pending flag stops the acknowledge there and puts its own vector address on the shared vector bus. Priority comes only from position: stage 0 sits nearest the processor and wins over every stage behind it.

The processor side works as a stream. `cpu_irq_o` acts as valid and `cpu_ack_i` acts as ready. A vector is transferred on every rising edge where both are high. That transfer clears the winning stage's flag, and the next pending stage becomes visible in the following cycle. While `cpu_ack_i` is low, the block applies back-pressure. No flag is lost or cleared, new requests add to the set of pending flags, and the vector bus stays at zero.

Each stage's vector is an entry of the `VEC_TABLE` parameter. With the default parameters, stage i uses vector 8'h10 + 4*i, so stage 0 is 8'h10 and stage 3 is 8'h1C. Vectors must be nonzero, because zero means that no stage is driving the bus.

Top module: `daisy_irq_chain`

## Requirements
- R1: After reset, every flag is clear. `cpu_irq_o` is 0, `vec_en_o` is all zero and `vec_bus_o` is 0.
- R2: A pulse on `dev_req_i[i]` sampled at a rising edge sets flag i. The flag appears on the outputs right after that edge and stays set until its vector is taken.
- R3: `cpu_irq_o` is 1 exactly when at least one stage's flag is set.
- R4: While `cpu_ack_i` is 1, the enabled stage is the lowest-index stage with a set flag, and `vec_bus_o` equals `VEC_TABLE` at that index.
- R5: A stage whose priority-in is 0 never enables, whatever its flag holds. With `cpu_ack_i` at 0, `vec_en_o` is all zero.
- R6: A stage with priority-in 1 and a clear flag passes the acknowledge on. `chain_out_o`, the priority-out of the last stage, is 1 exactly when `cpu_ack_i` is 1 and no flag is set.
- R7: At a rising edge where stage i is enabled, flag i clears. In the next cycle the next pending stage in order becomes the winner.
- R8: If a request pulse for stage i arrives in the same cycle that stage i's vector is taken, the flag stays set. The set wins over the clear.
- R9: At most one bit of `vec_en_o` is set at any time, and `vec_bus_o` is 0 whenever no stage is enabled.
- R10: While `cpu_ack_i` stays 0, flags are neither cleared nor lost. `cpu_irq_o` stays high once it has risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req_i | input | NUM_STAGES | One-cycle request pulse per stage, bit 0 highest priority |
| cpu_ack_i | input | 1 | Processor acknowledge (ready), priority-in of stage 0 |
| cpu_irq_o | output | 1 | Shared interrupt request (valid) |
| vec_bus_o | output | VEC_W | Vector of the enabled stage, zero when none |
| vec_en_o | output | NUM_STAGES | Per-stage vector enable |
| chain_out_o | output | 1 | Priority-out of the last stage |

## Verification
A flag that is stuck or wrongly cleared shows up on `cpu_irq_o` and on the winner order. The error is visible in the first cycle the acknowledge is high, because the enable and the bus follow the flags with no added register. A broken pass-through shows up in the same cycle as an enable that is missing or duplicated, or as a wrong vector. A faulty clear shows up one edge after a transfer, when the winner fails to move to the next pending stage.

// File: rtl/daisy_irq_pkg.sv
package daisy_irq_pkg;
  typedef struct packed {
    logic flag;
    logic prio_out;
    logic vec_en;
  } stage_view_t;
endpackage

// File: rtl/daisy_irq_stage.sv
module daisy_irq_stage
  import daisy_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_pulse,
  input  logic        prio_in,
  output stage_view_t view
);
  logic flag_q;
  logic claim;

  // claim only with priority-in high and a pending flag
  assign claim = prio_in & flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (req_pulse)  flag_q <= 1'b1;   // set beats clear
    else if (claim)      flag_q <= 1'b0;
  end

  always_comb begin
    view.flag     = flag_q;
    view.vec_en   = claim;
    view.prio_out = prio_in & ~flag_q;
  end
endmodule

// File: rtl/daisy_irq_collect.sv
module daisy_irq_collect #(
  parameter int NUM_STAGES = 4,
  parameter int VEC_W      = 8,
  parameter logic [NUM_STAGES-1:0][VEC_W-1:0] VEC_TABLE = '0
) (
  input  logic [NUM_STAGES-1:0] flags,
  input  logic [NUM_STAGES-1:0] enables,
  output logic                  irq_line,
  output logic [VEC_W-1:0]      vec_bus
);
  logic [NUM_STAGES-1:0][VEC_W-1:0] gated;

  genvar g;
  generate
    for (g = 0; g < NUM_STAGES; g++) begin : g_gate
      assign gated[g] = enables[g] ? VEC_TABLE[g] : '0;
    end
  endgenerate

  always_comb begin
    vec_bus = '0;
    for (int k = 0; k < NUM_STAGES; k++) vec_bus = vec_bus | gated[k];
  end

  assign irq_line = |flags;
endmodule

// File: rtl/daisy_irq_chain.sv
module daisy_irq_chain
  import daisy_irq_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int VEC_W      = 8,
  parameter logic [NUM_STAGES-1:0][VEC_W-1:0] VEC_TABLE = {8'h1C, 8'h18, 8'h14, 8'h10}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_STAGES-1:0] dev_req_i,
  input  logic                  cpu_ack_i,
  output logic                  cpu_irq_o,
  output logic [VEC_W-1:0]      vec_bus_o,
  output logic [NUM_STAGES-1:0] vec_en_o,
  output logic                  chain_out_o
);
  localparam int LAST = NUM_STAGES - 1;

  stage_view_t [NUM_STAGES-1:0] views;
  logic [NUM_STAGES-1:0] prio_in;
  logic [NUM_STAGES-1:0] flags;

  genvar s;
  generate
    for (s = 0; s < NUM_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_head
        assign prio_in[s] = cpu_ack_i;
      end else begin : g_link
        assign prio_in[s] = views[s-1].prio_out;
      end

      daisy_irq_stage u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_pulse (dev_req_i[s]),
        .prio_in   (prio_in[s]),
        .view      (views[s])
      );

      assign flags[s]    = views[s].flag;
      assign vec_en_o[s] = views[s].vec_en;
    end
  endgenerate

  assign chain_out_o = views[LAST].prio_out;

  daisy_irq_collect #(
    .NUM_STAGES (NUM_STAGES),
    .VEC_W      (VEC_W),
    .VEC_TABLE  (VEC_TABLE)
  ) u_collect (
    .flags    (flags),
    .enables  (vec_en_o),
    .irq_line (cpu_irq_o),
    .vec_bus  (vec_bus_o)
  );
endmodule

// File: rtl/daisy_irq_chain_chk.sv
module daisy_irq_chain_chk #(
  parameter int NUM_STAGES = 4,
  parameter int VEC_W      = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cpu_ack_i,
  input logic                  cpu_irq_o,
  input logic [VEC_W-1:0]      vec_bus_o,
  input logic [NUM_STAGES-1:0] vec_en_o
);
  a_r9_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec_en_o));

  a_r9_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_en_o == '0) |-> (vec_bus_o == '0));

  a_r5_no_ack_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ack_i |-> (vec_en_o == '0));

  a_r4_ack_finds_winner: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack_i && cpu_irq_o) |-> ($countones(vec_en_o) == 1));

  a_r3_quiet_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_irq_o |-> (vec_en_o == '0));

  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq_o && !cpu_ack_i) |=> cpu_irq_o);
endmodule

bind daisy_irq_chain daisy_irq_chain_chk #(
  .NUM_STAGES (NUM_STAGES),
  .VEC_W      (VEC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_ack_i (cpu_ack_i),
  .cpu_irq_o (cpu_irq_o),
  .vec_bus_o (vec_bus_o),
  .vec_en_o  (vec_en_o)
);

// File: tb/test_daisy_irq_chain.sv
`timescale 1ns/1ps
module test_daisy_irq_chain;
  localparam int N  = 4;
  localparam int VW = 8;
  localparam real HALF = 10.0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  dev_req_i = '0;
  logic          cpu_ack_i = 1'b0;
  logic          cpu_irq_o;
  logic [VW-1:0] vec_bus_o;
  logic [N-1:0]  vec_en_o;
  logic          chain_out_o;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] model = '0;

  always #(HALF) clk = ~clk;

  daisy_irq_chain i_daisy_irq_chain (
    .clk(clk), .rst_n(rst_n), .dev_req_i(dev_req_i), .cpu_ack_i(cpu_ack_i),
    .cpu_irq_o(cpu_irq_o), .vec_bus_o(vec_bus_o), .vec_en_o(vec_en_o),
    .chain_out_o(chain_out_o)
  );

  function automatic logic [N-1:0] exp_win(input logic [N-1:0] f, input logic ack);
    exp_win = '0;
    if (ack) begin
      for (int i = 0; i < N; i++)
        if (f[i]) begin exp_win[i] = 1'b1; break; end
    end
  endfunction

  function automatic logic [VW-1:0] exp_vec(input logic [N-1:0] w);
    exp_vec = '0;
    for (int i = 0; i < N; i++)
      if (w[i]) exp_vec = 8'h10 + 8'(4 * i);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check outputs, model update at posedge
  task automatic step(input logic [N-1:0] req, input logic ack, input string tag);
    logic [N-1:0] w;
    @(negedge clk);
    dev_req_i = req;
    cpu_ack_i = ack;
    #2;
    w = exp_win(model, ack);
    chk({tag, " irq R3"}, 32'(cpu_irq_o), 32'(|model));
    chk({tag, " enable R4"}, 32'(vec_en_o), 32'(w));
    chk({tag, " bus R9"}, 32'(vec_bus_o), 32'(exp_vec(w)));
    chk({tag, " tail R6"}, 32'(chain_out_o), 32'(ack && model == '0));
    @(posedge clk);
    model = (model & ~w) | req;
  endtask

  initial begin
    #(HALF * 2 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #2;
    chk("R1 irq after reset", 32'(cpu_irq_o), 0);
    chk("R1 enables after reset", 32'(vec_en_o), 0);
    chk("R1 bus after reset", 32'(vec_bus_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: single request sets flag, held without ack (R10)
    step(4'b0100, 1'b0, "R2 pulse");
    step(4'b0000, 1'b0, "R10 hold");
    step(4'b0000, 1'b0, "R10 hold");
    // R6 pass-through to stage 2, then R7 clear
    step(4'b0000, 1'b1, "R6 pass to stage2");
    step(4'b0000, 1'b1, "R7 after clear");
    // R5: pending flags but no ack, no enable; accumulate (R10)
    step(4'b1010, 1'b0, "R5 no ack");
    step(4'b0001, 1'b0, "R10 accumulate");
    step(4'b0000, 1'b0, "R5 still no ack");
    // R4/R7 ordered drain: 0 then 1 then 3
    step(4'b0000, 1'b1, "R4 drain first");
    step(4'b0000, 1'b1, "R7 drain second");
    step(4'b0000, 1'b1, "R7 drain third");
    step(4'b0000, 1'b1, "R6 empty chain");
    // R8: request to the winning stage during its transfer keeps it set
    step(4'b0010, 1'b0, "R8 setup");
    step(4'b0010, 1'b1, "R8 set beats clear");
    chk("R8 flag survives", 32'(model[1]), 1);
    step(4'b0000, 1'b1, "R8 served again");
    step(4'b0000, 1'b0, "R1 idle");

    for (int c = 0; c < 400; c++) begin
      logic [N-1:0] r;
      logic a;
      r = ($urandom % 4 == 0) ? N'($urandom) : '0;
      a = ($urandom % 3 != 0);
      step(r, a, "R4 random");
    end

    for (int d = 0; d < N + 2; d++) step('0, 1'b1, "R7 final drain");
    chk("R3 drained irq", 32'(cpu_irq_o), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule